// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

The unit multiplies two signed operands and adds the product into a 64-bit signed accumulator. The accumulator is read as a high word and a low word. Two operand modes exist. Long mode multiplies the full 32-bit signed operands. Word mode multiplies only the low 16 bits of each operand, taken as signed values.

A saturation-enable flag travels with each operation and changes how the sum is written back, and each mode has its own rule. In word mode, a sum outside the 32-bit signed range is clamped to the nearest limit, and the high word is set to 1 as an overflow marker. In long mode, only the upper bits of the high word are altered, according to the sign of the sum.

Software-side control is limited to a synchronous clear and two direct word loads that share one data input. An operation presented in cycle c lands in the accumulator in cycle c+2, and a one-cycle done pulse is raised in that same cycle.

Top module: `mac_sat_unit`

## Requirements
- R1: While rst_ni is low and right after it is released, acc_hi_o and acc_lo_o are 0 and done_o is 0.
- R2: An operation sampled with op_valid_i high in cycle c updates the accumulator in cycle c+2. done_o is high for exactly that one cycle per operation.
- R3: With mode_i=0 (long) and sat_i=0, both 32-bit operands are sign-extended and multiplied. The 64-bit product is added to the signed accumulator {acc_hi_o, acc_lo_o}, and the full sum is split back into the two words.
- R4: With mode_i=1 (word) and sat_i=0, only op_a_i[15:0] and op_b_i[15:0] are used, each as a signed 16-bit value. Bits 31:16 of the operands have no effect on the result.
- R5: In long mode with sat_i=1, the low word receives sum[31:0]. The high word receives sum[63:32] ORed with 0xFFFF0000 when the sum is negative, and ANDed with 0x00007FFF otherwise.
- R6: In word mode with sat_i=1, a sum below -2^31 writes 1 to the high word and 0x80000000 to the low word.
- R7: In word mode with sat_i=1, a sum above 2^31-1 writes 1 to the high word and 0x7FFFFFFF to the low word. Sums within [-2^31, 2^31-1], including both limits, are written unmodified.
- R8: clear_i high at a clock edge zeroes both words. It takes priority over loads and over an accumulate landing at the same edge.
- R9: load_hi_i or load_lo_i writes load_data_i into the selected word and leaves the other word unchanged. A load takes priority over an accumulate landing at the same edge, and that accumulate is discarded. done_o still pulses.
- R10: Operations on consecutive cycles each accumulate. The second operation adds to the result of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Start a multiply-accumulate this cycle |
| mode_i | input | 1 | 0 = long (32x32), 1 = word (16x16) |
| sat_i | input | 1 | Saturating write-back for this operation |
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B |
| clear_i | input | 1 | Zero both accumulator words |
| load_hi_i | input | 1 | Write load_data_i to the high word |
| load_lo_i | input | 1 | Write load_data_i to the low word |
| load_data_i | input | 32 | Data for word loads |
| acc_hi_o | output | 32 | Accumulator high word |
| acc_lo_o | output | 32 | Accumulator low word |
| done_o | output | 1 | One-cycle pulse when an operation lands |

## Verification
A wrong product or a wrong saturation choice shows up on acc_hi_o and acc_lo_o in cycle c+2, the same cycle as done_o. The vectors therefore compare both words exactly in that cycle. Errors in the high word are easy to miss, such as a wrong sign test in long mode or a missing overflow marker in word mode. For that reason the vectors start from loaded accumulator values that place the sum right next to each saturation limit. A lost or doubled stage-valid bit moves or repeats done_o, and a stale accumulator read corrupts back-to-back sums one cycle later, so both are checked cycle by cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    MODE_LONG = 1'b0,
    MODE_WORD = 1'b1
  } mac_mode_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  mac_pkg::mac_mode_e     mode_i,
  input  logic                   sat_i,
  input  logic [DATA_W-1:0]      a_i,
  input  logic [DATA_W-1:0]      b_i,
  output logic                   valid_o,
  output mac_pkg::mac_mode_e     mode_o,
  output logic                   sat_o,
  output logic [2*DATA_W-1:0]    prod_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int ACC_W  = 2 * DATA_W;

  logic signed [DATA_W-1:0] a_sel, b_sel;
  logic signed [ACC_W-1:0]  a_ext, b_ext, prod_c;

  always_comb begin
    if (mode_i == mac_pkg::MODE_WORD) begin
      a_sel = {{HALF_W{a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
      b_sel = {{HALF_W{b_i[HALF_W-1]}}, b_i[HALF_W-1:0]};
    end else begin
      a_sel = a_i;
      b_sel = b_i;
    end
    a_ext  = {{DATA_W{a_sel[DATA_W-1]}}, a_sel};
    b_ext  = {{DATA_W{b_sel[DATA_W-1]}}, b_sel};
    prod_c = a_ext * b_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mode_o  <= mac_pkg::MODE_LONG;
      sat_o   <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        mode_o <= mode_i;
        sat_o  <= sat_i;
        prod_o <= prod_c;
      end
    end
  end

  // R2: stage valid follows the request by one edge
  a_r2_stage_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_stage_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
  parameter int DATA_W = 32
) (
  input  logic [2*DATA_W-1:0]  acc_i,
  input  logic [2*DATA_W-1:0]  prod_i,
  input  mac_pkg::mac_mode_e   mode_i,
  input  logic                 sat_i,
  output logic [2*DATA_W-1:0]  res_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int ACC_W  = 2 * DATA_W;
  localparam logic signed [ACC_W-1:0] POS_LIM = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] NEG_LIM = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] HI_SET  = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
  localparam logic [DATA_W-1:0] HI_KEEP = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] W_MAX   = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] W_MIN   = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] OVF_HI  = DATA_W'(1);

  logic signed [ACC_W-1:0] sum;
  logic [DATA_W-1:0]       sum_hi, sum_lo;

  always_comb begin
    sum    = $signed(acc_i) + $signed(prod_i);
    sum_hi = sum[ACC_W-1:DATA_W];
    sum_lo = sum[DATA_W-1:0];
    res_o  = sum;
    if (sat_i) begin
      if (mode_i == mac_pkg::MODE_LONG) begin
        // long: only the top bits of the high word are patched
        res_o = sum[ACC_W-1] ? {sum_hi | HI_SET, sum_lo} : {sum_hi & HI_KEEP, sum_lo};
      end else if (sum < NEG_LIM) begin
        res_o = {OVF_HI, W_MIN};
      end else if (sum > POS_LIM) begin
        res_o = {OVF_HI, W_MAX};
      end
    end
  end
endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 load_hi_i,
  input  logic                 load_lo_i,
  input  logic [DATA_W-1:0]    load_data_i,
  input  logic                 upd_i,
  input  logic [2*DATA_W-1:0]  upd_val_i,
  output logic [DATA_W-1:0]    hi_o,
  output logic [DATA_W-1:0]    lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (clear_i) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (load_hi_i || load_lo_i) begin
      if (load_hi_i) hi_o <= load_data_i;
      if (load_lo_i) lo_o <= load_data_i;
    end else if (upd_i) begin
      {hi_o, lo_o} <= upd_val_i;
    end
  end

  // R8
  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (hi_o == '0 && lo_o == '0));
  // R9
  a_r9_load_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_hi_i && !clear_i) |=> hi_o == $past(load_data_i));
  a_r9_load_lo_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_lo_i && !load_hi_i && !clear_i) |=> (lo_o == $past(load_data_i) && $stable(hi_o)));
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              mode_i,
  input  logic              sat_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              clear_i,
  input  logic              load_hi_i,
  input  logic              load_lo_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] acc_hi_o,
  output logic [DATA_W-1:0] acc_lo_o,
  output logic              done_o
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;

  mac_pkg::mac_mode_e mode_in, st_mode;
  logic               st_valid, st_sat;
  logic [ACC_W-1:0]   st_prod, wb_val;

  assign mode_in = mac_pkg::mac_mode_e'(mode_i);

  mac_mult #(.DATA_W(DATA_W)) u_mult (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (op_valid_i),
    .mode_i  (mode_in),
    .sat_i   (sat_i),
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .valid_o (st_valid),
    .mode_o  (st_mode),
    .sat_o   (st_sat),
    .prod_o  (st_prod)
  );

  mac_sat #(.DATA_W(DATA_W)) u_sat (
    .acc_i  ({acc_hi_o, acc_lo_o}),
    .prod_i (st_prod),
    .mode_i (st_mode),
    .sat_i  (st_sat),
    .res_o  (wb_val)
  );

  mac_acc #(.DATA_W(DATA_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .load_hi_i   (load_hi_i),
    .load_lo_i   (load_lo_i),
    .load_data_i (load_data_i),
    .upd_i       (st_valid),
    .upd_val_i   (wb_val),
    .hi_o        (acc_hi_o),
    .lo_o        (acc_lo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= st_valid;
  end

  logic lands_clean;
  assign lands_clean = st_valid && st_sat && !clear_i && !load_hi_i && !load_lo_i;

  // R2
  a_r2_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |-> ##2 done_o);
  // R5
  a_r5_long_sat_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lands_clean && st_mode == mac_pkg::MODE_LONG) |=>
      (acc_hi_o[DATA_W-1] ? (&acc_hi_o[DATA_W-1:HALF_W]) : (acc_hi_o[DATA_W-1:HALF_W-1] == '0)));
  // R6 / R7
  a_r7_word_sat_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lands_clean && st_mode == mac_pkg::MODE_WORD) |=>
      ((acc_hi_o == '0 && !acc_lo_o[DATA_W-1]) ||
       (acc_hi_o == '1 &&  acc_lo_o[DATA_W-1]) ||
       (acc_hi_o == DATA_W'(1) &&
        (acc_lo_o == {1'b1, {(DATA_W-1){1'b0}}} || acc_lo_o == {1'b0, {(DATA_W-1){1'b1}}}))));
endmodule

// File: tb/tb_mac_sat_unit.sv
module tb_mac_sat_unit;
  localparam int CLK_PERIOD = 10;
  localparam longint W_MAX = (longint'(1) <<< 31) - 1;
  localparam longint W_MIN = -(longint'(1) <<< 31);

  typedef struct packed {
    logic [31:0] ihi;
    logic [31:0] ilo;
    logic        md;
    logic        st;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0,         32'h0,         1'b0, 1'b0, 32'h3,         32'hFFFF_FFFB},
    '{32'h0,         32'h0,         1'b0, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
    '{32'h0,         32'h0,         1'b1, 1'b0, 32'hABCD_8000, 32'h1234_0002},
    '{32'h0,         32'h7FFF_FFFF, 1'b1, 1'b0, 32'h1,         32'h1},
    '{32'h1234_5678, 32'h0,         1'b0, 1'b1, 32'h1_0000,    32'h1_0000},
    '{32'h0,         32'h0,         1'b0, 1'b1, 32'hFFFF_FFFF, 32'h1},
    '{32'h8000_0000, 32'h0,         1'b0, 1'b1, 32'h1,         32'h1},
    '{32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 1'b1, 32'h0000_FFFF, 32'h1},
    '{32'h0,         32'h7FFF_FFFF, 1'b1, 1'b1, 32'h1,         32'h1},
    '{32'h0,         32'h7FFF_FFFE, 1'b1, 1'b1, 32'h1,         32'h1},
    '{32'hFFFF_FFFF, 32'h8000_0001, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h1},
    '{32'h0,         32'h0,         1'b1, 1'b1, 32'hFFFF_0003, 32'h7FFF_0004}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic op_valid_i = 1'b0, mode_i = 1'b0, sat_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0, load_data_i = '0;
  logic clear_i = 1'b0, load_hi_i = 1'b0, load_lo_i = 1'b0;
  logic [31:0] acc_hi_o, acc_lo_o;
  logic done_o;
  int n_run = 0, n_fail = 0;

  mac_sat_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .mode_i(mode_i),
    .sat_i(sat_i), .op_a_i(op_a_i), .op_b_i(op_b_i), .clear_i(clear_i),
    .load_hi_i(load_hi_i), .load_lo_i(load_lo_i), .load_data_i(load_data_i),
    .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [63:0] model(logic [31:0] hi, logic [31:0] lo,
                                        logic md, logic st, logic [31:0] a, logic [31:0] b);
    longint acc, p, s;
    logic [31:0] h;
    acc = longint'({hi, lo});
    if (md) p = longint'(shortint'(a[15:0])) * longint'(shortint'(b[15:0]));
    else    p = longint'(int'(a)) * longint'(int'(b));
    s = acc + p;
    if (!st) return 64'(s);
    if (!md) begin
      h = s[63:32];
      h = (s < 0) ? (h | 32'hFFFF_0000) : (h & 32'h0000_7FFF);
      return {h, s[31:0]};
    end
    if (s < W_MIN) return {32'h1, 32'h8000_0000};
    if (s > W_MAX) return {32'h1, 32'h7FFF_FFFF};
    return 64'(s);
  endfunction

  function automatic string tag_of(logic md, logic st);
    if (!st) return md ? "R4" : "R3";
    return md ? "R6/R7" : "R5";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_word(input logic hi, input logic [31:0] d);
    @(negedge clk_i);
    load_hi_i = hi; load_lo_i = !hi; load_data_i = d;
    @(negedge clk_i);
    load_hi_i = 1'b0; load_lo_i = 1'b0;
  endtask

  // returns at the negedge inside cycle c+2
  task automatic run_op(input logic md, input logic st, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk_i);
    op_valid_i = 1'b1; mode_i = md; sat_i = st; op_a_i = a; op_b_i = b;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] keep;
    // R1
    #(CLK_PERIOD * 2 + 1);
    chk("R1 in reset", {acc_hi_o, acc_lo_o, 63'(done_o)}, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", {acc_hi_o, acc_lo_o}, '0);
    chk("R1 done low", 64'(done_o), 64'd0);

    for (int i = 0; i < NV; i++) begin
      load_word(1'b1, VECS[i].ihi);
      load_word(1'b0, VECS[i].ilo);
      chk("R9 preload", {acc_hi_o, acc_lo_o}, {VECS[i].ihi, VECS[i].ilo});
      run_op(VECS[i].md, VECS[i].st, VECS[i].a, VECS[i].b);
      chk(tag_of(VECS[i].md, VECS[i].st), {acc_hi_o, acc_lo_o},
          model(VECS[i].ihi, VECS[i].ilo, VECS[i].md, VECS[i].st, VECS[i].a, VECS[i].b));
      chk("R2 done at c+2", 64'(done_o), 64'd1);
    end

    // R4: upper operand bits ignored
    chk("R4 upper bits", {acc_hi_o, acc_lo_o}, 64'd12);

    // R2: single-cycle pulse, nothing early
    @(negedge clk_i);
    chk("R2 done one cycle", 64'(done_o), 64'd0);
    @(negedge clk_i);
    op_valid_i = 1'b1; mode_i = 1'b0; sat_i = 1'b0; op_a_i = 32'd5; op_b_i = 32'd5;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    chk("R2 not early", {acc_hi_o, acc_lo_o, 63'(done_o)}, {64'd12, 63'd0});
    @(negedge clk_i);
    chk("R2 lands", {acc_hi_o, acc_lo_o}, 64'd37);

    // R8: clear beats load
    @(negedge clk_i);
    clear_i = 1'b1; load_hi_i = 1'b1; load_data_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    clear_i = 1'b0; load_hi_i = 1'b0;
    chk("R8 clear over load", {acc_hi_o, acc_lo_o}, '0);

    // R8: clear beats a landing accumulate
    load_word(1'b0, 32'h55);
    @(negedge clk_i);
    op_valid_i = 1'b1; mode_i = 1'b0; sat_i = 1'b0; op_a_i = 32'd9; op_b_i = 32'd9;
    @(negedge clk_i);
    op_valid_i = 1'b0; clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    chk("R8 clear over accumulate", {acc_hi_o, acc_lo_o}, '0);

    // R9: load high only, low kept
    load_word(1'b0, 32'h1111_2222);
    load_word(1'b1, 32'h3333_4444);
    chk("R9 load hi keeps lo", {acc_hi_o, acc_lo_o}, 64'h3333_4444_1111_2222);

    // R9: load beats landing accumulate, done still pulses
    keep = {acc_hi_o, acc_lo_o};
    @(negedge clk_i);
    op_valid_i = 1'b1; mode_i = 1'b0; sat_i = 1'b0; op_a_i = 32'd100; op_b_i = 32'd100;
    @(negedge clk_i);
    op_valid_i = 1'b0; load_hi_i = 1'b1; load_data_i = 32'hCAFE_0001;
    @(negedge clk_i);
    load_hi_i = 1'b0;
    chk("R9 load over accumulate", {acc_hi_o, acc_lo_o}, {32'hCAFE_0001, keep[31:0]});
    chk("R9 done still pulses", 64'(done_o), 64'd1);

    // R10: back-to-back operations
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    op_valid_i = 1'b1; mode_i = 1'b0; sat_i = 1'b0; op_a_i = 32'd2; op_b_i = 32'd3;
    @(negedge clk_i);
    mode_i = 1'b1; op_a_i = 32'hFFFF_FFFC; op_b_i = 32'h0000_0005;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    chk("R10 first", {acc_hi_o, acc_lo_o}, 64'd6);
    @(negedge clk_i);
    chk("R10 second", {acc_hi_o, acc_lo_o}, 64'hFFFF_FFFF_FFFF_FFF2);
    chk("R10 second done", 64'(done_o), 64'd1);
    @(negedge clk_i);
    chk("R10 done drops", 64'(done_o), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule